// File: doc/BRIEF.md
# Raised-Cosine Symbol Pulse Shaper

This block turns a stream of binary symbols into a shaped baseband waveform for one rail of an offset-QPSK transmitter. A modulator instantiates it twice, once for the in-phase rail and once for the delayed quadrature rail. Each symbol is treated as an NRZ level of +1 or −1. The block convolves these levels with a smooth raised-cosine impulse response that spans three symbol periods.

No multiplier is used. The impulse response is cut into three constant tables, one symbol period long each. A single sample counter reads all three tables in parallel. The three most recent symbol bits each pick the sign of one table's sample, and the three signed samples are added and clipped into one output sample per enabled clock. The upstream mapper pulses a strobe at every symbol boundary. The strobe clears the counter and ages the bit history by one place on the same edge.

Top module: `rc_pulse_shaper`

## Requirements
- R1: While reset is asserted and after it is released, `smp_vld` is 0 and `smp_out` is 0, the symbol history is empty and the sample counter is 0.
- R2: On every enabled clock without a strobe, the sample counter advances by one. After SPS−1 it returns to 0, so a symbol that outlasts SPS cycles repeats the table addresses.
- R3: Table t (t = 0, 1, 2) at address a holds h[t·SPS + a], where h[k] = floor(PEAK·v²·(3L−2v)/L³), L = 3·SPS and v = L − |2k+1−L|. A slot whose bit is 1 adds +h and a slot whose bit is 0 adds −h.
- R4: On an enabled strobe, `sym_bit` enters slot 0 (the newest, tied to table 0). Slot 0 moves to slot 1, slot 1 moves to slot 2, and the old content of slot 2 is discarded.
- R5: A slot that has not yet received a bit since reset adds 0. Slots fill in order 0, 1, 2, one per strobe.
- R6: An enabled strobe sets the counter to 0 on the same edge, even in the middle of a symbol. The first sample formed after the strobe uses address 0 with the new history.
- R7: With `en` low, the counter and the history hold their values, a strobe is ignored, and `smp_vld` is 0 after that edge.
- R8: `smp_out` is a 13-bit two's-complement value with 12 fraction bits. A sum above 4095 gives 4095 and a sum below −4096 gives −4096. It never wraps.
- R9: The sample built from the counter and history in force at an enabled edge appears on `smp_out` with `smp_vld` = 1 right after that edge. Whenever `smp_vld` is 0, `smp_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable for the counter, the history and the sample output |
| sym_stb | input | 1 | Symbol boundary strobe |
| sym_bit | input | 1 | Symbol bit captured on the strobe (1 = +1, 0 = −1) |
| smp_out | output | OW (13) | Shaped sample, signed, 12 fraction bits |
| smp_vld | output | 1 | The sample is valid |

## Verification
The hardest case to reach is a strobe that does not land on the counter wrap. The new symbol must then start at address 0 while the older slots keep their signs, and a late strobe must let the counter wrap on its own first. The stimulus covers this with random symbol intervals on both sides of SPS, mixed with random enable gaps that carry ignored strobes.

Clipping cannot occur with the default coefficient scale. A second instance therefore runs at full-scale PEAK, and directed runs of identical bits drive it into both clip limits. A bench model checks every cycle, following the same coefficient formula, history ageing and clip rules as the requirements.

// File: rtl/psh_pkg.sv
package psh_pkg;

  // Raised-cosine-shaped tap k of a response span samples long, scaled to peak.
  function automatic int rc_coef(input int idx, input int span, input int peak);
    longint d;
    longint v;
    longint num;
    longint den;
    d = longint'(2 * idx + 1 - span);
    if (d < 0) d = -d;
    v   = longint'(span) - d;
    num = v * v * (3 * longint'(span) - 2 * v);
    den = longint'(span) * longint'(span) * longint'(span);
    return int'((longint'(peak) * num) / den);
  endfunction

  // Clip a signed value into an ow-bit two's-complement range.
  function automatic int clip_to(input int val, input int ow);
    int hi;
    int lo;
    hi = (1 << (ow - 1)) - 1;
    lo = -(1 << (ow - 1));
    if (val > hi) return hi;
    if (val < lo) return lo;
    return val;
  endfunction

endpackage

// File: rtl/psh_seq.sv
module psh_seq #(
  parameter int SPS  = 50,
  parameter int NSEG = 3,
  parameter int CNTW = $clog2(SPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            stb,
  input  logic            bit_in,
  output logic [CNTW-1:0] cnt,
  output logic [NSEG-1:0] hist,
  output logic [NSEG-1:0] hval
);

  logic shift_ev;
  logic last_ev;

  assign shift_ev = en & stb;
  assign last_ev  = (cnt == CNTW'(SPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (shift_ev) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= last_ev ? '0 : cnt + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      hval <= '0;
    end else if (shift_ev) begin
      hist[0] <= bit_in;
      hval[0] <= 1'b1;
      for (int s = 1; s < NSEG; s++) begin
        hist[s] <= hist[s-1];
        hval[s] <= hval[s-1];
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNTW'(SPS)); // R2
  AST_STB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> cnt == '0); // R6
  AST_HIST_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (hist[0] == $past(bit_in)) && hval[0]); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt) && $stable(hist) && $stable(hval)); // R7

  for (genvar s = 1; s < NSEG; s++) begin : g_chk
    AST_HIST_AGE: assert property (@(posedge clk) disable iff (!rst_n)
      shift_ev |=> (hist[s] == $past(hist[s-1])) && (hval[s] == $past(hval[s-1]))); // R4
    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      hval[s] |-> hval[s-1]); // R5
  end

endmodule

// File: rtl/psh_tap.sv
module psh_tap #(
  parameter int SPS  = 50,
  parameter int NSEG = 3,
  parameter int SEG  = 0,
  parameter int CW   = 12,
  parameter int SW   = 15,
  parameter int PEAK = 2600,
  parameter int CNTW = $clog2(SPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap,
  input  logic [CNTW-1:0]      addr,
  input  logic                 sgn,
  input  logic                 slot_v,
  output logic signed [SW-1:0] term
);
  import psh_pkg::*;

  localparam int SPAN = NSEG * SPS;

  logic [CW-1:0] rom [SPS];
  for (genvar a = 0; a < SPS; a++) begin : g_rom
    assign rom[a] = CW'(rc_coef(SEG * SPS + a, SPAN, PEAK));
  end

  logic [CW-1:0]        mag_q;
  logic                 sgn_q;
  logic                 v_q;
  logic signed [SW-1:0] mag_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      sgn_q <= 1'b0;
      v_q   <= 1'b0;
    end else if (cap) begin
      mag_q <= rom[addr];
      sgn_q <= sgn;
      v_q   <= slot_v;
    end
  end

  assign mag_ext = {{(SW-CW){1'b0}}, mag_q};
  assign term    = !v_q ? '0 : (sgn_q ? mag_ext : -mag_ext);

  AST_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !slot_v) |=> term == '0); // R5

endmodule

// File: rtl/psh_sum.sv
module psh_sum #(
  parameter int NSEG = 3,
  parameter int SW   = 15,
  parameter int OW   = 13
) (
  input  logic [NSEG*SW-1:0]   terms,
  output logic signed [SW-1:0] acc,
  output logic signed [OW-1:0] samp,
  output logic                 clip_hi,
  output logic                 clip_lo
);
  import psh_pkg::*;

  localparam int HI = (1 << (OW - 1)) - 1;
  localparam int LO = -(1 << (OW - 1));

  always_comb begin
    acc = '0;
    for (int s = 0; s < NSEG; s++) begin
      acc = acc + $signed(terms[s*SW +: SW]);
    end
  end

  assign clip_hi = int'(acc) > HI;
  assign clip_lo = int'(acc) < LO;
  assign samp    = OW'(clip_to(int'(acc), OW));

endmodule

// File: rtl/rc_pulse_shaper.sv
module rc_pulse_shaper #(
  parameter int SPS  = 50,
  parameter int NSEG = 3,
  parameter int CW   = 12,
  parameter int OW   = 13,
  parameter int PEAK = 2600
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 sym_stb,
  input  logic                 sym_bit,
  output logic signed [OW-1:0] smp_out,
  output logic                 smp_vld
);

  localparam int CNTW = $clog2(SPS);
  localparam int SW   = OW + $clog2(NSEG);
  localparam logic signed [OW-1:0] OUT_HI = OW'((1 << (OW - 1)) - 1);
  localparam logic signed [OW-1:0] OUT_LO = OW'(-(1 << (OW - 1)));

  logic [CNTW-1:0]      cnt;
  logic [NSEG-1:0]      hist;
  logic [NSEG-1:0]      hval;
  logic [NSEG*SW-1:0]   terms;
  logic signed [SW-1:0] acc;
  logic signed [OW-1:0] samp;
  logic                 clip_hi;
  logic                 clip_lo;
  logic                 vld_q;

  psh_seq #(.SPS(SPS), .NSEG(NSEG), .CNTW(CNTW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .stb(sym_stb), .bit_in(sym_bit),
    .cnt(cnt), .hist(hist), .hval(hval)
  );

  for (genvar t = 0; t < NSEG; t++) begin : g_tap
    logic signed [SW-1:0] term;
    psh_tap #(.SPS(SPS), .NSEG(NSEG), .SEG(t), .CW(CW), .SW(SW),
              .PEAK(PEAK), .CNTW(CNTW)) u_tap (
      .clk(clk), .rst_n(rst_n), .cap(en), .addr(cnt),
      .sgn(hist[t]), .slot_v(hval[t]), .term(term)
    );
    assign terms[t*SW +: SW] = term;
  end

  psh_sum #(.NSEG(NSEG), .SW(SW), .OW(OW)) u_sum (
    .terms(terms), .acc(acc), .samp(samp), .clip_hi(clip_hi), .clip_lo(clip_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= en;
  end

  assign smp_vld = vld_q;
  assign smp_out = vld_q ? samp : '0;

  AST_CLIP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && clip_hi) |-> smp_out == OUT_HI); // R8
  AST_CLIP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && clip_lo) |-> smp_out == OUT_LO); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |-> smp_out == '0); // R9
  AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> smp_vld); // R9

endmodule

// File: tb/rc_pulse_shaper_tb.sv
module rc_pulse_shaper_tb;

  localparam int SPS    = 50;
  localparam int NSEG   = 3;
  localparam int OW     = 13;
  localparam int PEAK_A = 2600;
  localparam int PEAK_B = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic sym_stb = 1'b0;
  logic sym_bit = 1'b0;
  logic signed [OW-1:0] out_a;
  logic signed [OW-1:0] out_b;
  logic vld_a;
  logic vld_b;

  always #2 clk = ~clk;

  rc_pulse_shaper #(.PEAK(PEAK_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sym_stb(sym_stb), .sym_bit(sym_bit),
    .smp_out(out_a), .smp_vld(vld_a)
  );

  rc_pulse_shaper #(.PEAK(PEAK_B)) u_sat (
    .clk(clk), .rst_n(rst_n), .en(en), .sym_stb(sym_stb), .sym_bit(sym_bit),
    .smp_out(out_b), .smp_vld(vld_b)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int hi_seen = 0;
  int lo_seen = 0;

  int  m_cnt = 0;
  bit  m_hist [NSEG];
  bit  m_hv [NSEG];
  bit  e_vld = 1'b0;
  int  e_a = 0;
  int  e_b = 0;

  function automatic int ref_coef(input int k, input int peak);
    longint L;
    longint x;
    longint t;
    L = 3 * SPS;
    x = 2 * k + 1;
    t = (x <= L) ? x : 2 * L - x;
    return int'(longint'(peak) * (3 * L * t * t - 2 * t * t * t) / (L * L * L));
  endfunction

  function automatic int ref_clip(input int v);
    if (v > 4095) return 4095;
    if (v < -4096) return -4096;
    return v;
  endfunction

  function automatic int ref_sample(input int peak);
    int acc;
    acc = 0;
    for (int s = 0; s < NSEG; s++) begin
      if (m_hv[s]) acc += m_hist[s] ? ref_coef(s * SPS + m_cnt, peak)
                                    : -ref_coef(s * SPS + m_cnt, peak);
    end
    return ref_clip(acc);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit e, input bit s, input bit b, input string tag);
    @(negedge clk);
    check(tag, int'(vld_a), int'(e_vld), "vld");
    check(tag, int'(out_a), e_a, "sample");
    check(tag, int'(vld_b), int'(e_vld), "vld(full-scale)");
    check(tag, int'(out_b), e_b, "sample(full-scale)");
    if (e_vld && e_b == 4095) hi_seen++;
    if (e_vld && e_b == -4096) lo_seen++;
    en = e; sym_stb = s; sym_bit = b;
    if (e) begin
      e_vld = 1'b1;
      e_a = ref_sample(PEAK_A);
      e_b = ref_sample(PEAK_B);
      if (s) begin
        for (int k = NSEG - 1; k > 0; k--) begin
          m_hist[k] = m_hist[k-1];
          m_hv[k] = m_hv[k-1];
        end
        m_hist[0] = b;
        m_hv[0] = 1'b1;
        m_cnt = 0;
      end else begin
        m_cnt = (m_cnt == SPS - 1) ? 0 : m_cnt + 1;
      end
    end else begin
      e_vld = 1'b0;
      e_a = 0;
      e_b = 0;
    end
  endtask

  task automatic symbol(input bit b, input int len, input string tag);
    step(1'b1, 1'b1, b, tag);
    for (int i = 1; i < len; i++) step(1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < NSEG; s++) begin
      m_hist[s] = 1'b0;
      m_hv[s] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check("R1", int'(vld_a), 0, "vld in reset");
    check("R1", int'(out_a), 0, "sample in reset");
    rst_n = 1'b1;
    // R1: idle cycles after release stay zero
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R1");
    // R2: counter runs with an empty history, so every sample is zero
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0, "R2 R5");
    // R5: slots fill one per strobe
    symbol(1'b1, SPS, "R5");
    symbol(1'b0, SPS, "R5");
    symbol(1'b1, SPS, "R5");
    // R3, R4: regular symbols with random bits
    for (int i = 0; i < 30; i++) symbol(1'($urandom_range(0, 1)), SPS, "R3 R4");
    // R6, R2: early and late strobes
    for (int i = 0; i < 40; i++)
      symbol(1'($urandom_range(0, 1)), int'($urandom_range(2, 90)), "R6 R2");
    // R7: enable gaps that carry strobes to be ignored
    for (int i = 0; i < 1500; i++) begin
      bit e;
      bit s;
      e = ($urandom_range(0, 9) < 7);
      s = ($urandom_range(0, 14) == 0);
      step(e, s, 1'($urandom_range(0, 1)), "R7 R9");
    end
    // R8: identical bit runs push the full-scale copy into both limits
    for (int i = 0; i < 5; i++) symbol(1'b1, SPS, "R8");
    for (int i = 0; i < 5; i++) symbol(1'b0, SPS, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, "R9");
    n_chk++;
    if (hi_seen == 0) begin
      n_bad++;
      $display("FAIL R8 upper clip reached: actual %0d expected >0", hi_seen);
    end
    n_chk++;
    if (lo_seen == 0) begin
      n_bad++;
      $display("FAIL R8 lower clip reached: actual %0d expected >0", lo_seen);
    end
    finish_run();
  end

endmodule